// File: doc/BRIEF.md
# Flash Status Auto-Polling Engine

This block automates the wait on a serial flash's status register. Once started, it asks a command sequencer for a status read, takes the 1 to 4 returned bytes as one value, and checks that value against a reference under a mask. If the check fails, the engine waits a programmable number of idle clock cycles and then reads again. If the check succeeds, it sets a sticky match flag, which can drive an interrupt line.

The comparison has two modes. In the all-bits mode every selected bit must agree with the reference. In the any-bit mode one agreeing selected bit is enough. When automatic stop is on, the first match ends polling and the engine returns to idle. When it is off, polling continues and every later match sets the flag again. An abort request ends polling at the next poll boundary without setting the flag. Software clears the flag with a one-cycle clear pulse.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, `busy`, `rd_req`, `match_flag` and `irq` are all 0.
- R2: A `start` pulse while idle makes `busy` and `rd_req` 1 in the following cycle. `rd_req` then stays 1 until a cycle in which `rd_done` is 1.
- R3: `cfg_size` codes 0, 1, 2 and 3 select 1, 2, 3 and 4 status bytes. Byte 0 sits in bits 7:0 and byte n in bits 8n+7:8n. Bits of bytes beyond the selected count are left out of the comparison, whatever `cfg_mask` holds.
- R4: With `cfg_or_mode`=0 (all-bits mode), a read matches when every selected mask bit of `rd_status` equals the same bit of `cfg_match`. An empty selection always matches.
- R5: With `cfg_or_mode`=1 (any-bit mode), a read matches when at least one selected mask bit of `rd_status` equals its `cfg_match` bit. An empty selection never matches.
- R6: After a read that does not end polling, `rd_req` is 0 for exactly `cfg_interval` cycles after the `rd_done` cycle and then returns to 1. With an interval of 0, `rd_req` stays 1.
- R7: With `cfg_auto_stop`=1, a matching read makes `busy` and `rd_req` 0 in the next cycle.
- R8: With `cfg_auto_stop`=0, a matching read leaves the engine polling, and each later matching read sets the flag again after a clear.
- R9: `match_flag` rises in the cycle after a matching `rd_done`. It holds until a `flag_clr` pulse clears it in the next cycle. A match in the same cycle as a clear wins, and the flag stays 1.
- R10: `irq` is 1 exactly when `match_flag` and `irq_en` are both 1.
- R11: `abort_req` while busy returns the engine to idle without setting the flag. If the engine is waiting out an interval, `busy` drops in the next cycle. If a read is outstanding, the engine completes that read, discards its result and goes idle in the cycle after its `rd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (taken only when idle) |
| abort_req | input | 1 | Stop polling at the next poll boundary |
| cfg_match | input | 32 | Reference status value |
| cfg_mask | input | 32 | Bits that take part in the comparison |
| cfg_interval | input | 16 | Idle cycles between reads |
| cfg_size | input | 2 | Status byte count minus one |
| cfg_or_mode | input | 1 | 0: all-bits match, 1: any-bit match |
| cfg_auto_stop | input | 1 | Stop polling on the first match |
| rd_req | output | 1 | Status read request to the sequencer |
| rd_done | input | 1 | Sequencer signals the read is complete |
| rd_status | input | 32 | Status bytes returned with `rd_done` |
| busy | output | 1 | Polling in progress |
| match_flag | output | 1 | Sticky status-match flag |
| flag_clr | input | 1 | Clear pulse for the match flag |
| irq_en | input | 1 | Interrupt enable for the match flag |
| irq | output | 1 | Match interrupt |

## Verification
The bench targets the following corner cases, and what a faulty design does in each:
- Status bytes with a mask of all ones and a short status size. A design that ignores the size compares stale upper bytes and misses real matches.
- An empty selection in each mode. A design that swaps the two mode reductions reports a match where none may exist, or the reverse.
- The exact length of the idle gap, including an interval of 0. An off-by-one timer shows up as a gap one cycle too long or too short.
- A clear pulse that coincides with a match, and aborts in both the gap and the outstanding-read phases. A design that gets these wrong loses a match, or raises a flag after an abort.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_GAP  = 2'd2
    } poll_state_e;
endpackage

// File: rtl/fsp_compare.sv
// Masked status comparison: lanes above the selected byte count are dropped.
module fsp_compare #(
    parameter int BYTES = 4,
    localparam int W      = 8 * BYTES,
    localparam int SIZE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [W-1:0]      status,
    input  logic [W-1:0]      match_val,
    input  logic [W-1:0]      mask,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              or_mode,
    output logic              hit
);
    logic [W-1:0] size_mask;
    logic [W-1:0] eff_mask;
    logic [W-1:0] agree;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign size_mask[8*b +: 8] = {8{SIZE_W'(b) <= size_code}};
    end

    always_comb begin
        eff_mask = mask & size_mask;
        agree    = ~(status ^ match_val) & eff_mask;
        hit      = or_mode ? (|agree) : (agree == eff_mask);
    end
endmodule

// File: rtl/fsp_gap_timer.sv
// Down-counter spacing two status reads; expire marks the last idle cycle.
module fsp_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import fsp_pkg::*;
#(
    parameter int STATUS_BYTES = 4,
    parameter int INTERVAL_W   = 16,
    localparam int DATA_W = 8 * STATUS_BYTES,
    localparam int SIZE_W = (STATUS_BYTES > 1) ? $clog2(STATUS_BYTES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  abort_req,
    input  logic [DATA_W-1:0]     cfg_match,
    input  logic [DATA_W-1:0]     cfg_mask,
    input  logic [INTERVAL_W-1:0] cfg_interval,
    input  logic [SIZE_W-1:0]     cfg_size,
    input  logic                  cfg_or_mode,
    input  logic                  cfg_auto_stop,
    output logic                  rd_req,
    input  logic                  rd_done,
    input  logic [DATA_W-1:0]     rd_status,
    output logic                  busy,
    output logic                  match_flag,
    input  logic                  flag_clr,
    input  logic                  irq_en,
    output logic                  irq
);
    typedef struct packed {
        poll_state_e st;
        logic        flag;
        logic        abort_pend;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit;
    logic  timer_load;
    logic  gap_expire;

    fsp_compare #(.BYTES(STATUS_BYTES)) i_compare (
        .status    (rd_status),
        .match_val (cfg_match),
        .mask      (cfg_mask),
        .size_code (cfg_size),
        .or_mode   (cfg_or_mode),
        .hit       (hit)
    );

    fsp_gap_timer #(.CNT_W(INTERVAL_W)) i_gap_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (cfg_interval),
        .expire   (gap_expire)
    );

    always_comb begin
        r_d        = r_q;
        timer_load = 1'b0;
        if (flag_clr) r_d.flag = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st         = ST_READ;
                    r_d.abort_pend = 1'b0;
                end
            end
            ST_READ: begin
                if (abort_req) r_d.abort_pend = 1'b1;
                if (rd_done) begin
                    if (abort_req || r_q.abort_pend) begin
                        // poll boundary reached with an abort pending: drop result
                        r_d.st         = ST_IDLE;
                        r_d.abort_pend = 1'b0;
                    end else begin
                        if (hit) r_d.flag = 1'b1;
                        if (hit && cfg_auto_stop) begin
                            r_d.st = ST_IDLE;
                        end else if (cfg_interval != '0) begin
                            r_d.st     = ST_GAP;
                            timer_load = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (abort_req || r_q.abort_pend) begin
                    r_d.st         = ST_IDLE;
                    r_d.abort_pend = 1'b0;
                end else if (gap_expire) begin
                    r_d.st = ST_READ;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign rd_req     = (r_q.st == ST_READ);
    assign busy       = (r_q.st != ST_IDLE);
    assign match_flag = r_q.flag;
    assign irq        = r_q.flag & irq_en;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic abort_req,
    input logic rd_req,
    input logic rd_done,
    input logic busy,
    input logic match_flag,
    input logic flag_clr
);
    assert_req_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_done) |=> rd_req);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && rd_req));

    assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(rd_req && rd_done));

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && flag_clr && !(rd_req && rd_done)) |=> !match_flag);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !flag_clr) |=> match_flag);

    assert_abort_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && busy && !rd_req) |=> !busy);
endmodule

bind flash_status_poller fsp_checker i_fsp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .abort_req  (abort_req),
    .rd_req     (rd_req),
    .rd_done    (rd_done),
    .busy       (busy),
    .match_flag (match_flag),
    .flag_clr   (flag_clr)
);

// File: tb/test_flash_status_poller.sv
`timescale 1ns/1ps
module test_flash_status_poller;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort_req = 1'b0;
    logic [31:0] cfg_match = '0, cfg_mask = '0;
    logic [15:0] cfg_interval = '0;
    logic [1:0]  cfg_size = '0;
    logic        cfg_or_mode = 1'b0, cfg_auto_stop = 1'b1;
    logic        rd_req, rd_done = 1'b0;
    logic [31:0] rd_status = '0;
    logic        busy, match_flag, irq;
    logic        flag_clr = 1'b0, irq_en = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    flash_status_poller i_flash_status_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .abort_req(abort_req),
        .cfg_match(cfg_match), .cfg_mask(cfg_mask), .cfg_interval(cfg_interval),
        .cfg_size(cfg_size), .cfg_or_mode(cfg_or_mode), .cfg_auto_stop(cfg_auto_stop),
        .rd_req(rd_req), .rd_done(rd_done), .rd_status(rd_status), .busy(busy),
        .match_flag(match_flag), .flag_clr(flag_clr), .irq_en(irq_en), .irq(irq)
    );

    function automatic logic [31:0] eff_mask(logic [31:0] k, logic [1:0] sz);
        logic [31:0] lanes;
        lanes = (sz == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (int'(sz) + 1))) - 32'h1);
        return k & lanes;
    endfunction

    function automatic bit exp_hit(logic [31:0] st, logic [31:0] m, logic [31:0] k,
                                   logic [1:0] sz, bit orm);
        logic [31:0] em, ag;
        em = eff_mask(k, sz);
        ag = ~(st ^ m) & em;
        return orm ? (ag != 0) : (ag == em);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_read(input logic [31:0] st, input bit clr);
        while (!rd_req) tick();
        rd_done   = 1'b1;
        rd_status = st;
        flag_clr  = clr;
        tick();
        rd_done  = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic clear_flag;
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic kick;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic pulse_abort;
        abort_req = 1'b1;
        tick();
        abort_req = 1'b0;
    endtask

    function automatic int gap_len_dummy();
        return 0;
    endfunction

    task automatic measure_gap(output int n);
        n = 0;
        while (!rd_req && n < 70000) begin
            n++;
            tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        int n;
        seed = $urandom(32'h1F2E3D4C);
        #12;
        check("R1 busy", busy, 0);
        check("R1 rd_req", rd_req, 0);
        check("R1 flag", match_flag, 0);
        check("R1 irq", irq, 0);
        rst_n = 1'b1;
        tick();

        // R3: one byte selected, upper bytes of status differ from reference
        cfg_size = 2'd0; cfg_mask = 32'hFFFF_FFFF; cfg_match = 32'h0000_00AA;
        cfg_or_mode = 1'b0; cfg_auto_stop = 1'b1; cfg_interval = 16'd2;
        kick();
        check("R2 busy after start", busy, 1);
        check("R2 rd_req after start", rd_req, 1);
        do_read(32'hFFFF_FFAA, 1'b0);
        check("R3 one-byte match flag", match_flag, 1);
        check("R7 auto stop busy", busy, 0);
        check("R7 auto stop rd_req", rd_req, 0);
        clear_flag();
        check("R9 cleared", match_flag, 0);

        // R3: same data with four bytes selected must not match
        cfg_size = 2'd3;
        kick();
        do_read(32'hFFFF_FFAA, 1'b0);
        check("R3 four-byte no match", match_flag, 0);
        check("R3 still busy", busy, 1);
        pulse_abort();
        check("R11 abort in gap", busy, 0);

        // R4 / R5 empty selection
        cfg_mask = 32'h0; cfg_or_mode = 1'b0;
        kick();
        do_read(32'h1234_5678, 1'b0);
        check("R4 empty mask matches", match_flag, 1);
        clear_flag();
        cfg_or_mode = 1'b1; cfg_interval = 16'd1;
        kick();
        do_read(32'h0000_00AA, 1'b0);
        check("R5 empty mask no match", match_flag, 0);
        pulse_abort();
        check("R11 abort idle", busy, 0);

        // R5 one agreeing bit suffices
        cfg_mask = 32'h0000_0F00; cfg_size = 2'd1; cfg_match = 32'h0000_0100;
        kick();
        do_read(32'h0000_01F0 ^ 32'h0000_0E00, 1'b0);
        check("R5 single bit match", match_flag, 1);
        clear_flag();

        // R6 gap length, R8 continuing polling, R9 set beats clear
        cfg_or_mode = 1'b0; cfg_auto_stop = 1'b0; cfg_interval = 16'd3;
        cfg_mask = 32'h0000_00FF; cfg_size = 2'd0; cfg_match = 32'h0000_0003;
        kick();
        do_read(32'h0000_0003, 1'b0);
        check("R8 first match flag", match_flag, 1);
        check("R8 still busy", busy, 1);
        measure_gap(n);
        check("R6 gap of 3", n, 3);
        clear_flag();
        check("R9 clear while polling", match_flag, 0);
        do_read(32'h0000_0003, 1'b0);
        check("R8 second match flag", match_flag, 1);
        do_read(32'h0000_0003, 1'b1);
        check("R9 set wins over clear", match_flag, 1);
        irq_en = 1'b1; #1;
        check("R10 irq on", irq, 1);
        irq_en = 1'b0; #1;
        check("R10 irq masked", irq, 0);
        clear_flag();
        cfg_interval = 16'd0;
        do_read(32'h0000_0000, 1'b0);
        check("R6 zero gap keeps rd_req", rd_req, 1);
        pulse_abort();
        check("R11 abort waits for read", busy, 1);
        do_read(32'h0000_0003, 1'b0);
        check("R11 matching read discarded", match_flag, 0);
        check("R11 idle after read", busy, 0);
        irq_en = 1'b1;

        // random polls
        for (int it = 0; it < 150; it++) begin
            logic [31:0] st, em;
            bit e;
            cfg_match     = $urandom;
            cfg_mask      = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
            cfg_size      = 2'($urandom_range(0, 3));
            cfg_or_mode   = 1'($urandom_range(0, 1));
            cfg_auto_stop = 1'b1;
            cfg_interval  = 16'($urandom_range(0, 5));
            em = eff_mask(cfg_mask, cfg_size);
            st = $urandom;
            if ($urandom_range(0, 1) == 1) st = (cfg_match & em) | (st & ~em);
            e = exp_hit(st, cfg_match, cfg_mask, cfg_size, cfg_or_mode);
            clear_flag();
            kick();
            for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
                tick();
                check("R2 rd_req held", rd_req, 1);
            end
            do_read(st, 1'b0);
            check(cfg_or_mode ? "R5 random compare" : "R4 random compare", match_flag, 32'(e));
            check("R10 random irq", irq, 32'(e));
            check("R7 random busy", busy, 32'(!e));
            if (!e) begin
                measure_gap(n);
                check("R6 random gap", n, 32'(cfg_interval));
                pulse_abort();
                do_read((cfg_match & em) | (st & ~em), 1'b0);
                check("R11 random abort flag", match_flag, 0);
                check("R11 random abort idle", busy, 0);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule